// File: doc/BRIEF.md
# Fan Stall Guard

This block watches the tachometer edges of a single-phase fan and decides whether the rotor has stalled. While the drive runs, a watchdog window is restarted by every edge of the tachometer signal. If the window expires with no edge, the block enters a protect phase. In that phase it asks the output stage to switch both coil outputs off and it releases the lock indicator. The protect phase lasts a fixed multiple of the drive window, ten by default. At its end the block returns to the drive window and sends a one-cycle restart strobe, so the startup logic can begin again at full duty.

The lock indicator is active low (pulled low) while the rotor turns. It is released for the whole protect phase. After a release it comes back only on the first tachometer edge, not when the protect phase ends. A standby flag overrides all of this: the indicator is held low, protection is masked and the timer is cleared. Leaving standby also produces a restart strobe. A run-enable input can hold the watchdog cleared while the drive is paused. The window lengths are given in milliseconds against a clock-frequency parameter, and the counter width is derived from them.

Top module: `fan_stall_guard`

## Requirements
- R1: While reset is asserted, `lockProtect` is 0, `rdLow` is 1 and `restartPulse` is 0.
- R2: In the drive window, with `runEn` high and `standby` low, `lockProtect` rises after exactly D clock edges without an `fgEdge` strobe. D is `CLK_HZ/1000*DRIVE_MS`. Reset counts as the start of the window.
- R3: An `fgEdge` strobe sampled in the drive window restarts the window, so lock follows D edges after the last sampled strobe. Strobes spaced fewer than D cycles apart never produce lock.
- R4: The protect phase lasts exactly `OFF_RATIO`*D cycles. After that, `lockProtect` returns to 0 and a new drive window starts from zero.
- R5: `restartPulse` is high for exactly one cycle: the first cycle after the protect phase ends.
- R6: `rdLow` goes to 0 in the cycle `lockProtect` rises. It stays 0 after the release until the first `fgEdge` sampled in the drive window, and returns to 1 in the cycle after that strobe.
- R7: `fgEdge` strobes during the protect phase have no effect: they neither shorten the phase nor bring `rdLow` back.
- R8: While `standby` is 1, `rdLow` is 1 and `lockProtect` is 0 in the same cycle. The watchdog is cleared, so lock after standby needs a full D edges.
- R9: When `standby` falls, `restartPulse` is high for one cycle: the cycle after the first edge that samples `standby` low. Entering standby gives no strobe.
- R10: While `runEn` is 0 in the drive window, the watchdog is held at zero and no lock occurs. Lock then needs D edges after `runEn` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fgEdge | input | 1 | One-cycle strobe for each tachometer transition, either direction |
| runEn | input | 1 | Drive running; low holds the watchdog cleared |
| standby | input | 1 | Standby flag; overrides the lock state |
| lockProtect | output | 1 | High during the protect phase; gates the coil outputs off |
| rdLow | output | 1 | Lock indicator; 1 = pin pulled low (rotating or standby), 0 = released |
| restartPulse | output | 1 | One-cycle request for a full-duty restart |

## Verification
The stall path is first driven with no tachometer edges from reset, which fixes the exact window and protect lengths. A single strobe is then placed shortly after a release, which separates a restarted window from a free-running one and shows that the indicator waits for rotation. A strobe placed inside the protect phase shows that the phase is neither cut short nor cleared early. A standby interval longer than the window, a paused run-enable and a steady strobe train spaced just under the window separate the masking, clearing and holding paths from a real stall.

// File: rtl/fan_lock_pkg.sv
package fan_lock_pkg;

  typedef enum logic {
    ST_DRIVE   = 1'b0,
    ST_PROTECT = 1'b1
  } lockState_t;

  // strobes from control to the shared window timer
  typedef struct packed {
    logic clr;
    logic inc;
  } cntCtl_t;

endpackage

// File: rtl/fan_lock_timer.sv
module fan_lock_timer
  import fan_lock_pkg::*;
#(
  parameter int unsigned DRIVE_CYCLES = 20,
  parameter int unsigned OFF_CYCLES   = 200,
  parameter int unsigned CNT_W        = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  cntCtl_t ctl,
  output logic    atDriveEnd,
  output logic    atOffEnd
);

  localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(DRIVE_CYCLES - 1);
  localparam logic [CNT_W-1:0] OFF_LAST   = CNT_W'(OFF_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ctl.clr) begin
      cnt <= '0;
    end else if (ctl.inc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign atDriveEnd = (cnt == DRIVE_LAST);
  assign atOffEnd   = (cnt == OFF_LAST);

  // R4: the shared counter never runs past the longer (off) window
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= OFF_LAST)
    else $error("window counter past off limit");

  // R4: a clear request always lands at zero
  p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clr |=> (cnt == '0))
    else $error("counter not cleared");

endmodule

// File: rtl/fan_lock_ctrl.sv
module fan_lock_ctrl
  import fan_lock_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fgEdge,
  input  logic    runEn,
  input  logic    standby,
  input  logic    atDriveEnd,
  input  logic    atOffEnd,
  output cntCtl_t ctl,
  output logic    lockProtect,
  output logic    rdLow,
  output logic    restartPulse
);

  lockState_t state, stateNext;
  logic rdLatch, rdNext;
  logic standbyDly;
  logic enterProt, protDone;
  logic restartNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    enterProt = 1'b0;
    protDone  = 1'b0;
    if (standby) begin
      ctl.clr   = 1'b1;
      stateNext = ST_DRIVE;
    end else begin
      case (state)
        ST_DRIVE: begin
          if (!runEn || fgEdge) begin
            ctl.clr = 1'b1;
          end else if (atDriveEnd) begin
            ctl.clr   = 1'b1;
            stateNext = ST_PROTECT;
            enterProt = 1'b1;
          end else begin
            ctl.inc = 1'b1;
          end
        end
        ST_PROTECT: begin
          if (atOffEnd) begin
            ctl.clr   = 1'b1;
            stateNext = ST_DRIVE;
            protDone  = 1'b1;
          end else begin
            ctl.inc = 1'b1;
          end
        end
        default: stateNext = ST_DRIVE;
      endcase
    end
  end

  always_comb begin
    if (standby) begin
      rdNext = 1'b1;
    end else if (enterProt) begin
      rdNext = 1'b0;
    end else if (state == ST_DRIVE && fgEdge) begin
      rdNext = 1'b1;
    end else begin
      rdNext = rdLatch;
    end
  end

  assign restartNext = protDone | (standbyDly & ~standby);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_DRIVE;
      rdLatch      <= 1'b1;
      standbyDly   <= 1'b0;
      restartPulse <= 1'b0;
    end else begin
      state        <= stateNext;
      rdLatch      <= rdNext;
      standbyDly   <= standby;
      restartPulse <= restartNext;
    end
  end

  assign lockProtect = (state == ST_PROTECT) & ~standby;
  assign rdLow       = rdLatch | standby;

  // R2: protection is entered only after a cycle with no strobe while running
  p_quiet_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROTECT && $past(state) == ST_DRIVE) |-> (!$past(fgEdge) && $past(runEn)))
    else $error("lock entered despite strobe or pause");

  // R5: restart request is a single-cycle strobe
  p_single_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restartPulse |=> !restartPulse)
    else $error("restart strobe longer than one cycle");

  // R5: leaving the protect phase raises the restart request
  p_release_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRIVE && $past(state) == ST_PROTECT && !$past(standby)) |-> restartPulse)
    else $error("release without restart strobe");

  // R6: indicator stays released throughout the protect phase
  p_rd_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROTECT) |-> !rdLatch)
    else $error("indicator active during protection");

  // R7: strobes cannot end the protect phase early
  p_fg_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROTECT && !standby && !atOffEnd) |=> (state == ST_PROTECT))
    else $error("protect phase cut short");

  // R8: standby always returns the controller to the drive window
  p_standby_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (state == ST_DRIVE))
    else $error("standby did not clear lock");

  // R10: a paused drive cannot enter protection
  p_pause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRIVE && !runEn && !standby) |=> (state == ST_DRIVE))
    else $error("lock while paused");

endmodule

// File: rtl/fan_stall_guard.sv
module fan_stall_guard
  import fan_lock_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned DRIVE_MS  = 600,
  parameter int unsigned OFF_RATIO = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fgEdge,
  input  logic runEn,
  input  logic standby,
  output logic lockProtect,
  output logic rdLow,
  output logic restartPulse
);

  localparam int unsigned DRIVE_CYCLES = (CLK_HZ / 1000) * DRIVE_MS;
  localparam int unsigned OFF_CYCLES   = DRIVE_CYCLES * OFF_RATIO;
  localparam int unsigned CNT_W        = (OFF_CYCLES > 1) ? $clog2(OFF_CYCLES) : 1;

  cntCtl_t ctl;
  logic    atDriveEnd;
  logic    atOffEnd;

  fan_lock_timer #(
    .DRIVE_CYCLES(DRIVE_CYCLES),
    .OFF_CYCLES  (OFF_CYCLES),
    .CNT_W       (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .atDriveEnd(atDriveEnd),
    .atOffEnd  (atOffEnd)
  );

  fan_lock_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fgEdge      (fgEdge),
    .runEn       (runEn),
    .standby     (standby),
    .atDriveEnd  (atDriveEnd),
    .atOffEnd    (atOffEnd),
    .ctl         (ctl),
    .lockProtect (lockProtect),
    .rdLow       (rdLow),
    .restartPulse(restartPulse)
  );

endmodule

// File: tb/fan_stall_guard_test.sv
`timescale 1ns/1ps
module fan_stall_guard_test;

  localparam int unsigned CLK_HZ    = 10_000;
  localparam int unsigned DRIVE_MS  = 2;
  localparam int unsigned OFF_RATIO = 10;
  localparam int D   = 20;   // CLK_HZ/1000*DRIVE_MS
  localparam int OFF = 200;  // D*OFF_RATIO

  logic clk = 1'b0;
  logic rst_n, fgEdge, runEn, standby;
  logic lockProtect, rdLow, restartPulse;

  always #2 clk = ~clk;  // 250 MHz

  fan_stall_guard #(.CLK_HZ(CLK_HZ), .DRIVE_MS(DRIVE_MS), .OFF_RATIO(OFF_RATIO)) uut (
    .clk(clk), .rst_n(rst_n), .fgEdge(fgEdge), .runEn(runEn), .standby(standby),
    .lockProtect(lockProtect), .rdLow(rdLow), .restartPulse(restartPulse)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    sig;
    logic  val;
    string req;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic expectAt(int at, int sig, logic val, string req);
    item_t it;
    it.at = at; it.sig = sig; it.val = val; it.req = req;
    expQ.push_back(it);
  endtask

  function automatic logic pick(int sig);
    case (sig)
      0:       return lockProtect;
      1:       return rdLow;
      default: return restartPulse;
    endcase
  endfunction

  function automatic string sigName(int sig);
    case (sig)
      0:       return "lockProtect";
      1:       return "rdLow";
      default: return "restartPulse";
    endcase
  endfunction

  // monitor: compares queued expectations away from the clock edge
  always @(negedge clk) begin
    #1;
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].at == cyc) begin
        checks++;
        if (pick(expQ[i].sig) !== expQ[i].val) begin
          fails++;
          $display("FAIL %s %s cycle %0d actual=%b expected=%b",
                   expQ[i].req, sigName(expQ[i].sig), cyc, pick(expQ[i].sig), expQ[i].val);
        end
        expQ.delete(i);
      end
    end
  end

  task automatic waitUntil(int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic pulse();
    fgEdge = 1'b1;
    @(negedge clk);
    fgEdge = 1'b0;
  endtask

  initial begin
    int c, p, r, p2, s, p3, r3, q, t, p4, r4, k;
    rst_n = 1'b0; fgEdge = 1'b0; runEn = 1'b1; standby = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state
    c = cyc;
    expectAt(c, 0, 1'b0, "R1");
    expectAt(c, 1, 1'b1, "R1");
    expectAt(c, 2, 1'b0, "R1");
    rst_n = 1'b1;

    // R2 / R6: stall from reset
    p = c + D;
    r = p + OFF;
    expectAt(p - 1, 0, 1'b0, "R2");
    expectAt(p,     0, 1'b1, "R2");
    expectAt(p - 1, 1, 1'b1, "R6");
    expectAt(p,     1, 1'b0, "R6");
    // R4 / R5: protect length and restart strobe
    expectAt(r - 1, 0, 1'b1, "R4");
    expectAt(r,     0, 1'b0, "R4");
    expectAt(r - 1, 2, 1'b0, "R5");
    expectAt(r,     2, 1'b1, "R5");
    expectAt(r + 1, 2, 1'b0, "R5");
    expectAt(r,     1, 1'b0, "R6");

    // R7: strobe inside the protect phase is ignored
    waitUntil(p + 50);
    expectAt(p + 52, 1, 1'b0, "R7");
    expectAt(p + 52, 0, 1'b1, "R7");
    pulse();

    // R6 / R3: first strobe after release
    waitUntil(r + 5);
    expectAt(r + 5, 1, 1'b0, "R6");
    expectAt(r + 6, 1, 1'b1, "R6");
    expectAt(r + D, 0, 1'b0, "R3");
    expectAt(r + 6 + D - 1, 0, 1'b0, "R3");
    expectAt(r + 6 + D,     0, 1'b1, "R3");
    pulse();

    // R8: standby during protection
    p2 = r + 6 + D;
    waitUntil(p2 + 9);
    expectAt(p2 + 9, 1, 1'b0, "R8");
    @(negedge clk);
    expectAt(p2 + 10, 0, 1'b0, "R8");
    expectAt(p2 + 10, 1, 1'b1, "R8");
    expectAt(p2 + 11, 2, 1'b0, "R9");
    standby = 1'b1;
    waitUntil(p2 + 39);
    expectAt(p2 + 39, 0, 1'b0, "R8");
    @(negedge clk);

    // R9: leaving standby
    s = p2 + 40;
    expectAt(s,     2, 1'b0, "R9");
    expectAt(s + 1, 2, 1'b1, "R9");
    expectAt(s + 2, 2, 1'b0, "R9");
    expectAt(s + D - 1, 0, 1'b0, "R8");
    expectAt(s + D,     0, 1'b1, "R8");
    standby = 1'b0;

    // R10: paused drive holds the watchdog
    p3 = s + D;
    r3 = p3 + OFF;
    waitUntil(r3 + 2);
    q = r3 + 2;
    runEn = 1'b0;
    expectAt(q + D + 5, 0, 1'b0, "R10");
    expectAt(q + 3 * D, 0, 1'b0, "R10");
    waitUntil(q + 3 * D);
    t = cyc;
    expectAt(t + D - 1, 0, 1'b0, "R10");
    expectAt(t + D,     0, 1'b1, "R10");
    runEn = 1'b1;

    // R3: steady rotation just under the window never locks
    p4 = t + D;
    r4 = p4 + OFF;
    waitUntil(r4 + 1);
    k = cyc;
    for (int n = 0; n < 8; n++) begin
      k = cyc;
      expectAt(k, 0, 1'b0, "R3");
      pulse();
      repeat (D - 3) @(negedge clk);
    end
    expectAt(cyc, 1, 1'b1, "R6");
    expectAt(k + D,     0, 1'b0, "R3");
    expectAt(k + 1 + D, 0, 1'b1, "R3");
    waitUntil(k + D + 4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d actual=running expected=finished", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule